// File: doc/BRIEF.md
# SD/MMC Card Clock Generator with Soft Reset Sequencer

This block derives the card clock of an SD/MMC host from a fixed reference clock (nominally 24 MHz). The division ratio is a power of two, 2^n with n from 0 to 7, so the slowest card clock is the reference divided by 128. The card clock leaves the block in two forms. One is a one-cycle enable pulse, `cclk_tick`, in the last reference cycle of every card-clock period. The other is a phase level, `cclk_lvl`, which is high in the first half of each period. The command and data shifters downstream advance on the enable pulse.

Software controls the block through three word registers: a write-only control strobe register, a status register and a rate register. Starting and stopping the clock are requested transitions that the block performs without glitches. A stop lets the period in progress finish, so no runt pulse appears, and software polls a running flag until it drops. A soft reset lasts a fixed number of reference cycles and is reported through a busy flag. The control register also carries a command-start bit, which the block passes on to the command engine as a single pulse.

Top module: `cclk_ctrl`

## Requirements
- R1: After `rst_n` is released, the status, rate and control registers all read 0, and `cclk_tick`, `cclk_lvl` and `cmd_start` are low.
- R2: While running with rate n (rate register at `addr`=2, bits [2:0]), `cclk_tick` pulses exactly once every 2^n reference cycles, for every n from 0 to 7.
- R3: Writing the control register (`addr`=0) with bits [1:0]=10 starts a stopped clock. Status bit 8 (`addr`=1) is high in the cycle after the write, and the first tick comes 2^n-1 cycles after that.
- R4: Writing control bits [1:0]=01 to a running clock lets the current period run to its end. The tick of that period is the last one. Status bit 8 clears in the following cycle, and no tick and no high `cclk_lvl` appear afterwards.
- R5: Control bits [1:0]=11 or 00 change neither the running state nor the period of the clock.
- R6: A rate written while the clock runs takes effect only after the current period has ended. A rate written while the clock is stopped is used by the next start. The rate register reads back the value written.
- R7: Control bit 2 gives a one-cycle `cmd_start` pulse in the cycle after the write, including when the same write also starts the clock.
- R8: Control bit 3 raises status bit 15 for exactly 16 cycles. It stops the clock at once, clears the rate to 0 and suppresses a command bit in the same write. Control and rate writes are ignored while bit 15 is high. After the reset a start runs at n=0.
- R9: Reading the control register always returns 0.
- R10: While running with n at least 1, `cclk_lvl` is high for 2^(n-1) of the 2^n cycles in each period, ending low on the tick cycle. With n=0 it stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register word address (0 control, 1 status, 2 rate) |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for `addr`, combinational |
| cclk_tick | output | 1 | Card-clock enable, one pulse per card period |
| cclk_lvl | output | 1 | Card-clock phase level |
| cmd_start | output | 1 | One-cycle start pulse to the command engine |

## Verification
The divider is swept over all eight rates. Each rate is started from stopped and stopped again, so the first-tick delay, the steady period, the high-phase length and the stop point are all measured per rate. An off-by-one in the mask or the half-phase compare shows up at one specific n.

A rate change is written two cycles into an 8-cycle period. This separates a change applied at the period boundary from one applied at once. The invalid strobe codes 11 and 00 are written to both a stopped and a running clock.

The soft reset is issued while the clock runs, together with a command bit. Rate and start writes are made inside the busy window, which shows whether each write was ignored or took effect.

// File: rtl/cclk_pkg.sv
package cclk_pkg;
   // register word addresses
   localparam int A_CTRL = 0;
   localparam int A_STAT = 1;
   localparam int A_RATE = 2;
   // control strobe bit positions
   localparam int CB_STOP  = 0;
   localparam int CB_START = 1;
   localparam int CB_CMD   = 2;
   localparam int CB_RST   = 3;
   // status bit positions
   localparam int SB_RUN = 8;
   localparam int SB_RST = 15;

   typedef enum logic [1:0] {
      CK_HOLD  = 2'b00,
      CK_STOP  = 2'b01,
      CK_START = 2'b10,
      CK_BOTH  = 2'b11
   } ck_req_e;
endpackage

// File: rtl/cclk_regs.sv
module cclk_regs
   import cclk_pkg::*;
#(
   parameter int ADDR_W = 2,
   parameter int DATA_W = 16,
   parameter int DIV_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              busy,
   output ck_req_e           ck_req,
   output logic              rst_go,
   output logic              cmd_pulse,
   output logic [DIV_W-1:0]  rate_pend
);
   logic wr_ctrl;

   assign wr_ctrl = wr_en && (addr == ADDR_W'(A_CTRL)) && !busy;
   assign rst_go  = wr_ctrl && wr_data[CB_RST];
   assign ck_req  = (wr_ctrl && !wr_data[CB_RST]) ?
                    ck_req_e'(wr_data[CB_START:CB_STOP]) : CK_HOLD;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_pulse <= 1'b0;
         rate_pend <= '0;
      end else begin
         cmd_pulse <= wr_ctrl && wr_data[CB_CMD] && !wr_data[CB_RST];
         if (busy || rst_go)
            rate_pend <= '0;
         else if (wr_en && (addr == ADDR_W'(A_RATE)))
            rate_pend <= wr_data[DIV_W-1:0];
      end
   end
endmodule

// File: rtl/cclk_divider.sv
module cclk_divider
   import cclk_pkg::*;
#(
   parameter int DIV_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  ck_req_e          ck_req,
   input  logic [DIV_W-1:0] rate_pend,
   output logic             tick,
   output logic             lvl,
   output logic             running
);
   localparam int CNT_W = (1 << DIV_W) - 1;
   localparam logic [DIV_W-1:0] NMAX     = '1;
   localparam logic [CNT_W-1:0] CNT_ONES = '1;

   logic [DIV_W-1:0] rate_cur;
   logic [CNT_W-1:0] cnt, cnt_n, mask;
   logic             run_q, run_n, stop_pend, stop_n, boundary;

   assign mask     = CNT_ONES >> (NMAX - rate_cur);
   assign boundary = run_q && (cnt == mask);

   always_comb begin
      run_n  = run_q;
      stop_n = stop_pend;
      cnt_n  = cnt;
      if (run_q) cnt_n = boundary ? '0 : cnt + 1'b1;
      if (boundary && stop_pend) begin
         run_n  = 1'b0;
         stop_n = 1'b0;
         cnt_n  = '0;
      end
      case (ck_req)
         CK_START: begin
            stop_n = 1'b0;
            if (!run_q) cnt_n = '0;
            run_n = 1'b1;
         end
         CK_STOP: if (run_n) stop_n = 1'b1;
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q     <= 1'b0;
         stop_pend <= 1'b0;
         cnt       <= '0;
         rate_cur  <= '0;
      end else if (clr) begin
         run_q     <= 1'b0;
         stop_pend <= 1'b0;
         cnt       <= '0;
         rate_cur  <= '0;
      end else begin
         run_q     <= run_n;
         stop_pend <= stop_n;
         cnt       <= cnt_n;
         if (!run_q || boundary) rate_cur <= rate_pend;
      end
   end

   assign tick    = boundary;
   assign lvl     = run_q && (cnt <= (mask >> 1));
   assign running = run_q;

   // R4: gating only happens on the last cycle of a period
   p_gate_at_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run_q) && !$past(clr) |-> $past(tick));
   // R6: the applied rate never moves inside a running period
   p_rate_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(run_q) && run_q && !$past(tick) |-> $stable(rate_cur));
   // R2: a divided period is never shorter than two cycles
   p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tick && (rate_cur != '0) |=> !tick || (rate_cur == '0));
endmodule

// File: rtl/cclk_reset_seq.sv
module cclk_reset_seq #(
   parameter int RST_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   output logic busy
);
   localparam int CW = $clog2(RST_CYCLES);
   localparam logic [CW-1:0] LOAD = CW'(RST_CYCLES - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (go && !busy) begin
         busy <= 1'b1;
         cnt  <= LOAD;
      end else if (busy) begin
         if (cnt == '0) busy <= 1'b0;
         else           cnt  <= cnt - 1'b1;
      end
   end

   // R8: a reset never collapses to a single cycle
   p_rst_min_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |=> busy);
endmodule

// File: rtl/cclk_ctrl.sv
module cclk_ctrl
   import cclk_pkg::*;
#(
   parameter int ADDR_W     = 2,
   parameter int DATA_W     = 16,
   parameter int DIV_W      = 3,
   parameter int RST_CYCLES = 16,
   parameter int RD_LAT     = 0
) (
   input  logic              clk_ref,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              cclk_tick,
   output logic              cclk_lvl,
   output logic              cmd_start
);
   if (DATA_W < 16) begin : g_bad_data
      $error("DATA_W must hold status bit 15");
   end
   if (DIV_W < 1 || DIV_W > 4) begin : g_bad_div
      $error("DIV_W out of range 1..4");
   end
   if (RST_CYCLES < 2) begin : g_bad_rst
      $error("RST_CYCLES must be at least 2");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("ADDR_W must cover three registers");
   end

   ck_req_e          ck_req;
   logic             rst_go, busy, running, clr;
   logic [DIV_W-1:0] rate_pend;
   logic [DATA_W-1:0] rd_mux;

   cclk_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W)) u_regs (
      .clk(clk_ref), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wr_data(wr_data), .busy(busy), .ck_req(ck_req), .rst_go(rst_go),
      .cmd_pulse(cmd_start), .rate_pend(rate_pend));

   cclk_reset_seq #(.RST_CYCLES(RST_CYCLES)) u_rst (
      .clk(clk_ref), .rst_n(rst_n), .go(rst_go), .busy(busy));

   assign clr = rst_go || busy;

   cclk_divider #(.DIV_W(DIV_W)) u_div (
      .clk(clk_ref), .rst_n(rst_n), .clr(clr), .ck_req(ck_req),
      .rate_pend(rate_pend), .tick(cclk_tick), .lvl(cclk_lvl),
      .running(running));

   always_comb begin
      rd_mux = '0;
      if (addr == ADDR_W'(A_STAT)) begin
         rd_mux[SB_RUN] = running;
         rd_mux[SB_RST] = busy;
      end else if (addr == ADDR_W'(A_RATE)) begin
         rd_mux = DATA_W'(rate_pend);
      end
   end

   if (RD_LAT == 0) begin : g_rd_comb
      assign rd_data = rd_mux;
   end else begin : g_rd_reg
      always_ff @(posedge clk_ref or negedge rst_n) begin
         if (!rst_n) rd_data <= '0;
         else        rd_data <= rd_mux;
      end
   end

   // R8: the reset sequence holds the clock stopped
   p_busy_stops_r8: assert property (@(posedge clk_ref) disable iff (!rst_n)
      busy |-> !running);
   // R7: no command pulse escapes during a reset
   p_cmd_not_in_rst_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
      cmd_start |-> !busy);
endmodule

// File: tb/cclk_ctrl_test.sv
module cclk_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [15:0] wr_data = 16'd0;
   logic [15:0] rd_data;
   logic        cclk_tick, cclk_lvl, cmd_start;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   cclk_ctrl uut (
      .clk_ref(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data), .cclk_tick(cclk_tick),
      .cclk_lvl(cclk_lvl), .cmd_start(cmd_start));

   always #4 clk = ~clk;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      #2;
   endtask

   task automatic wr(input int a, input int d);
      addr = 2'(a);
      wr_data = 16'(d);
      wr_en = 1'b1;
      cyc();
      wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output logic [15:0] v);
      addr = 2'(a);
      #1;
      v = rd_data;
   endtask

   // advance to the next tick; k = cycles taken, h = high-level samples seen
   task automatic next_tick(output int k, output int h);
      k = 0;
      h = 0;
      do begin
         cyc();
         k++;
         if (cclk_lvl) h++;
      end while (!cclk_tick && k < 400);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R2 watchdog actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] s;
      int k, h, lt, bad;
      repeat (3) cyc();
      rst_n = 1'b1;
      cyc();
      // R1 reset state, R9 control reads zero
      rd(0, s); chk("R9 ctrl read", s, 0);
      rd(1, s); chk("R1 status", s, 0);
      rd(2, s); chk("R1 rate", s, 0);
      chk("R1 tick", cclk_tick, 0);
      chk("R1 lvl", cclk_lvl, 0);
      chk("R1 cmd", cmd_start, 0);

      for (int n = 0; n < 8; n++) begin
         wr(2, n);
         rd(2, s); chk("R6 rate readback", s, n);
         wr(0, 2);
         rd(1, s); chk("R3 running after start", s[8], 1);
         if (cclk_tick) k = 0; else next_tick(k, h);
         chk("R3 first tick delay", k, (1 << n) - 1);
         for (int g = 0; g < 3; g++) begin
            next_tick(k, h);
            chk("R2 period", k, 1 << n);
            chk("R10 high phase", h, (n == 0) ? 1 : (1 << (n - 1)));
         end
         wr(0, 1);
         k = 0; lt = -1;
         rd(1, s);
         while (s[8] && k < 400) begin
            if (cclk_tick) lt = k;
            cyc();
            k++;
            rd(1, s);
         end
         chk("R4 stop point", k, 1 << n);
         chk("R4 last tick", lt, (1 << n) - 1);
         bad = 0;
         for (int c = 0; c < (1 << n) + 3; c++) begin
            cyc();
            if (cclk_tick || cclk_lvl) bad++;
         end
         chk("R4 quiet after stop", bad, 0);
      end

      // R5 invalid codes
      wr(0, 3);
      bad = 0;
      for (int c = 0; c < 4; c++) begin cyc(); if (cclk_tick) bad++; end
      rd(1, s); chk("R5 11 on stopped clock", s[8], 0);
      chk("R5 no ticks", bad, 0);
      wr(2, 1);
      wr(0, 2);
      next_tick(k, h);
      wr(0, 3);
      wr(0, 0);
      rd(1, s); chk("R5 still running", s[8], 1);
      next_tick(k, h);
      next_tick(k, h);
      chk("R5 period unchanged", k, 2);
      rd(0, s); chk("R9 ctrl read after writes", s, 0);

      // R6 rate change while running
      wr(2, 3);
      next_tick(k, h);
      next_tick(k, h);
      next_tick(k, h);
      chk("R6 new rate period", k, 8);
      cyc();
      cyc();
      wr(2, 0);
      k = 3;
      while (!cclk_tick && k < 50) begin cyc(); k++; end
      chk("R6 old period completes", k, 8);
      cyc(); chk("R6 new rate applied", cclk_tick, 1);
      cyc(); chk("R6 new rate steady", cclk_tick, 1);

      // R7 command pulse
      wr(0, 4);
      chk("R7 cmd pulse", cmd_start, 1);
      cyc();
      chk("R7 cmd pulse width", cmd_start, 0);
      wr(0, 1);
      k = 0;
      rd(1, s);
      while (s[8] && k < 20) begin cyc(); k++; rd(1, s); end
      chk("R4 stopped before combined start", s[8], 0);
      wr(0, 6);
      chk("R7 cmd with start", cmd_start, 1);
      rd(1, s); chk("R7 start with cmd", s[8], 1);
      wr(2, 2);
      next_tick(k, h);

      // R8 soft reset with cmd bit, writes during busy
      wr(0, 12);
      rd(1, s);
      chk("R8 busy set", s[15], 1);
      chk("R8 clock stopped", s[8], 0);
      chk("R8 cmd suppressed", cmd_start, 0);
      k = 0;
      while (s[15] && k < 100) begin
         k++;
         if (k == 3) wr(2, 5);
         else if (k == 6) wr(0, 2);
         else cyc();
         rd(1, s);
      end
      chk("R8 busy length", k, 16);
      chk("R8 start ignored", s[8], 0);
      rd(2, s); chk("R8 rate cleared", s, 0);
      bad = 0;
      for (int c = 0; c < 5; c++) begin cyc(); if (cclk_tick) bad++; end
      chk("R8 no ticks after reset", bad, 0);
      wr(0, 2);
      chk("R8 restart at n=0", cclk_tick, 1);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule